// File: doc/BRIEF.md
# Programmable Clock Fanout Controller

This block is the digital control core of a three-lane clock fanout stage. A source clock, sampled as a level on a faster system clock, is distributed to three output lanes. Lane 0 always carries the source undivided. Lanes 1 and 2 can each be parked or fed from one shared free-running binary divider, so every divided lane stays phase-aligned with the others. A mode is picked with three three-level select inputs, and a three-level enable gates the whole block. High impedance is modelled as a per-lane drive flag.

After the enable rises, the block runs a settle phase in which every driven lane is held high for a set number of source rising edges. The lanes then drop low and wait for the next source rising edge, where the divider starts and lane 0 starts to follow the source. Per-lane enables mute a single lane without touching the shared divider. A re-enabled lane therefore picks up whatever phase the divider already holds.

Top module: `clkfan_ctrl`

## Requirements
- R1: While `rst_n` is low, `clk_out`, `out_drive` and `mode_err` are all zero.
- R2: Three-level inputs use the code 00 for low, 01 for mid and 11 for high; 10 is invalid. At any clock edge where `en_sel` is not 11, the next values are `out_drive` = 0, `clk_out` = 0 and `mode_err` = 0. The divider and the settle count clear, and the select inputs have no effect.
- R3: The first enabled edge starts the settle phase. In this phase each driven lane is high. The phase ends on the SETTLE_EDGES-th source rising edge seen after it began. The lanes then drive low until the next source rising edge.
- R4: At that next rising edge, the run phase begins. From then on, lane 0 shows on `clk_out[0]` the `src_clk` level sampled at the previous clock edge.
- R5: The mode index is t = 9*s2 + 3*s1 + s0, where low = 0, mid = 1 and high = 2. For t below 25, lane 1 takes code (t+1) mod 5 and lane 2 takes code t/5 + 1 (integer division). Code 0 means the lane is off, and code c ≥ 1 means divide by 2^(c-1).
- R6: The divider starts at zero when the run phase begins. It counts every source rising edge seen in the run phase. A lane with code c ≥ 2 shows bit c-2 of the divider value after that edge, and a lane with code 1 shows the sampled source level.
- R7: An index of 25 or 26, or any select input at code 10, raises `mode_err` while the block is enabled. It also turns lanes 1 and 2 off.
- R8: A lane whose `out_en` bit is low has its drive and its level at 0. The divider keeps counting regardless, so a lane that is re-enabled shows the current divider phase.
- R9: Selects are sampled on the clock. A select change shows on the outputs at the first clock edge after it is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the source |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_clk | input | 1 | Source clock level to distribute |
| en_sel | input | 2 | Three-level global enable |
| sel0 | input | 2 | Three-level mode select, weight 1 |
| sel1 | input | 2 | Three-level mode select, weight 3 |
| sel2 | input | 2 | Three-level mode select, weight 9 |
| out_en | input | 3 | Per-lane enable |
| clk_out | output | 3 | Lane clock levels |
| out_drive | output | 3 | Lane driven (1) or high impedance (0) |
| mode_err | output | 1 | Reserved or invalid select code present |

## Verification
Several functions can act on the same clock edge. A disable can land on the very edge where a source rising edge would have advanced the settle count or the divider. A per-lane enable change can land on a divider step, and a select change can land on a source edge. The bench provokes these cases by sweeping disables and control changes across different source phases and two source periods. A behavioural reference model predicts every lane on every cycle, so each collision is judged by exact agreement of the levels, the drives and the error flag.

// File: rtl/clkfan_pkg.sv
package clkfan_pkg;

    typedef enum logic [1:0] {
        ST_OFF    = 2'd0,
        ST_SETTLE = 2'd1,
        ST_ARMED  = 2'd2,
        ST_RUN    = 2'd3
    } fan_state_e;

    localparam logic [1:0] TRI_LO  = 2'b00;
    localparam logic [1:0] TRI_MID = 2'b01;
    localparam logic [1:0] TRI_HI  = 2'b11;

    typedef struct packed {
        logic [2:0] code1;
        logic [2:0] code2;
        logic       err;
    } fan_mode_t;

    function automatic int tri_weight(input logic [1:0] c);
        case (c)
            TRI_LO:  return 0;
            TRI_MID: return 1;
            TRI_HI:  return 2;
            default: return 0;
        endcase
    endfunction

    function automatic logic tri_bad(input logic [1:0] c);
        return (c == 2'b10);
    endfunction

endpackage

// File: rtl/clkfan_mode_dec.sv
module clkfan_mode_dec
    import clkfan_pkg::*;
#(
    parameter int LANE1_CHOICES = 5,
    parameter int VALID_MODES   = 25
) (
    input  logic [1:0] sel0,
    input  logic [1:0] sel1,
    input  logic [1:0] sel2,
    output fan_mode_t  mode
);
    always_comb begin
        int  idx;
        logic bad;
        bad  = tri_bad(sel0) | tri_bad(sel1) | tri_bad(sel2);
        idx  = 9 * tri_weight(sel2) + 3 * tri_weight(sel1) + tri_weight(sel0);
        mode = '0;
        if (bad || idx >= VALID_MODES) begin
            mode.err = 1'b1;
        end else begin
            mode.code1 = 3'((idx + 1) % LANE1_CHOICES);
            mode.code2 = 3'(idx / LANE1_CHOICES + 1);
        end
    end
endmodule

// File: rtl/clkfan_tap.sv
module clkfan_tap #(
    parameter int DIV_W = 4
) (
    input  logic [2:0]       code,
    input  logic             src,
    input  logic [DIV_W-1:0] div,
    output logic             on,
    output logic             lvl
);
    always_comb begin
        on  = (code != 3'd0);
        lvl = 1'b0;
        if (code == 3'd1) lvl = src;
        for (int k = 0; k < DIV_W; k++) begin
            if (int'(code) == k + 2) lvl = div[k];
        end
    end
endmodule

// File: rtl/clkfan_ctrl.sv
module clkfan_ctrl
    import clkfan_pkg::*;
#(
    parameter int SETTLE_EDGES = 8,
    parameter int DIV_W        = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       src_clk,
    input  logic [1:0] en_sel,
    input  logic [1:0] sel0,
    input  logic [1:0] sel1,
    input  logic [1:0] sel2,
    input  logic [2:0] out_en,
    output logic [2:0] clk_out,
    output logic [2:0] out_drive,
    output logic       mode_err
);
    localparam int SW    = $clog2(SETTLE_EDGES + 1);
    localparam int LANES = 3;

    typedef struct packed {
        fan_state_e       st;
        logic [SW-1:0]    settle;
        logic [DIV_W-1:0] div;
        logic             src;
        logic             err;
        logic [LANES-1:0] y;
        logic [LANES-1:0] v;
    } fan_regs_t;

    fan_regs_t r_d, r_q;
    fan_mode_t mode;
    logic [LANES-1:0] lane_on, lane_lvl;
    logic [DIV_W-1:0] div_next;
    logic             rise;

    clkfan_mode_dec u_dec (
        .sel0 (sel0),
        .sel1 (sel1),
        .sel2 (sel2),
        .mode (mode)
    );

    assign rise     = src_clk & ~r_q.src;
    assign div_next = (r_q.st == ST_RUN && rise) ? r_q.div + 1'b1 : r_q.div;

    assign lane_on[0]  = 1'b1;
    assign lane_lvl[0] = src_clk;

    for (genvar g = 1; g < LANES; g++) begin : g_tap
        clkfan_tap #(.DIV_W(DIV_W)) u_tap (
            .code (g == 1 ? mode.code1 : mode.code2),
            .src  (src_clk),
            .div  (div_next),
            .on   (lane_on[g]),
            .lvl  (lane_lvl[g])
        );
    end

    always_comb begin
        r_d     = r_q;
        r_d.src = src_clk;
        if (en_sel != TRI_HI) begin
            r_d.st     = ST_OFF;
            r_d.settle = '0;
            r_d.div    = '0;
            r_d.err    = 1'b0;
            r_d.y      = '0;
            r_d.v      = '0;
        end else begin
            r_d.div = div_next;
            case (r_q.st)
                ST_OFF: begin
                    r_d.st     = ST_SETTLE;
                    r_d.settle = '0;
                end
                ST_SETTLE: begin
                    if (rise) begin
                        if (r_q.settle == SW'(SETTLE_EDGES - 1)) begin
                            r_d.st     = ST_ARMED;
                            r_d.settle = '0;
                        end else begin
                            r_d.settle = r_q.settle + 1'b1;
                        end
                    end
                end
                ST_ARMED: begin
                    if (rise) r_d.st = ST_RUN;
                end
                default: ;
            endcase
            r_d.err = mode.err;
            r_d.v   = out_en & lane_on;
            case (r_d.st)
                ST_SETTLE: r_d.y = out_en & lane_on;
                ST_RUN:    r_d.y = out_en & lane_on & lane_lvl;
                default:   r_d.y = '0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign clk_out   = r_q.y;
    assign out_drive = r_q.v;
    assign mode_err  = r_q.err;

endmodule

// File: rtl/clkfan_chk.sv
module clkfan_chk
    import clkfan_pkg::*;
#(
    parameter int DW = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic          src_clk,
    input logic [1:0]    en_sel,
    input logic [2:0]    out_en,
    input logic [2:0]    clk_out,
    input logic [2:0]    out_drive,
    input logic          mode_err,
    input fan_state_e    st_q,
    input logic [DW-1:0] div_q
);
    assert_disabled_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (en_sel != TRI_HI) |=> (out_drive == 3'b000 && mode_err == 1'b0));

    assert_settle_high_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_SETTLE) |-> (clk_out == out_drive));

    assert_lane0_follows_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_RUN && out_drive[0]) |-> (clk_out[0] == $past(src_clk)));

    assert_div_single_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_RUN && $past(st_q) == ST_RUN) |->
        (div_q == $past(div_q) || div_q == DW'($past(div_q) + 1'b1)));

    assert_err_mutes_R7: assert property (@(posedge clk) disable iff (!rst_n)
        mode_err |-> (out_drive[2:1] == 2'b00));

    assert_drive_within_enable_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ((out_drive & ~$past(out_en)) == 3'b000));
endmodule

bind clkfan_ctrl clkfan_chk #(.DW(DIV_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .src_clk   (src_clk),
    .en_sel    (en_sel),
    .out_en    (out_en),
    .clk_out   (clk_out),
    .out_drive (out_drive),
    .mode_err  (mode_err),
    .st_q      (r_q.st),
    .div_q     (r_q.div)
);

// File: tb/tb_clkfan_ctrl.sv
module tb_clkfan_ctrl;
    localparam int SETTLE = 8;

    logic       clk   = 1'b0;
    logic       rst_n = 1'b0;
    logic       src   = 1'b0;
    logic [1:0] en    = 2'b11;
    logic [1:0] s0    = 2'b00;
    logic [1:0] s1    = 2'b00;
    logic [1:0] s2    = 2'b00;
    logic [2:0] oe    = 3'b111;
    wire  [2:0] y;
    wire  [2:0] drv;
    wire        err;

    always #10 clk = ~clk;

    clkfan_ctrl #(.SETTLE_EDGES(SETTLE), .DIV_W(4)) dut (
        .clk(clk), .rst_n(rst_n), .src_clk(src), .en_sel(en),
        .sel0(s0), .sel1(s1), .sel2(s2), .out_en(oe),
        .clk_out(y), .out_drive(drv), .mode_err(err)
    );

    int n_vec = 0, n_bad = 0;
    int m_st = 0, m_cnt = 0, m_div = 0;
    bit m_srcp = 0, m_err = 0, m_rise = 0, m_bad = 0;
    bit [2:0] m_y = 0, m_v = 0;
    int m_c[3];
    int m_idx = 0;
    bit sel_chg = 0, done = 0;
    int half = 2, ph = 0;

    function automatic int tern(input logic [1:0] c);
        if (c == 2'b00) return 0;
        if (c == 2'b01) return 1;
        if (c == 2'b11) return 2;
        return -1;
    endfunction

    function automatic logic [1:0] enc(input int d);
        return (d == 0) ? 2'b00 : (d == 1) ? 2'b01 : 2'b11;
    endfunction

    // behavioural reference, updated on the same edge as the design
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_st = 0; m_cnt = 0; m_div = 0; m_srcp = 0;
            m_err = 0; m_y = 0; m_v = 0;
        end else begin
            m_rise = src && !m_srcp;
            m_srcp = src;
            if (en != 2'b11) begin
                m_st = 0; m_cnt = 0; m_div = 0; m_err = 0; m_y = 0; m_v = 0;
            end else begin
                if (m_st == 0) begin
                    m_st = 1; m_cnt = 0;
                end else if (m_st == 1) begin
                    if (m_rise) begin
                        m_cnt++;
                        if (m_cnt == SETTLE) begin m_st = 2; m_cnt = 0; end
                    end
                end else if (m_st == 2) begin
                    if (m_rise) m_st = 3;
                end else if (m_rise) begin
                    m_div = (m_div + 1) % 16;
                end
                m_bad = tern(s0) < 0 || tern(s1) < 0 || tern(s2) < 0;
                m_idx = 9 * tern(s2) + 3 * tern(s1) + tern(s0);
                m_c[0] = 1;
                if (m_bad || m_idx > 24) begin
                    m_err = 1; m_c[1] = 0; m_c[2] = 0;
                end else begin
                    m_err = 0; m_c[1] = (m_idx + 1) % 5; m_c[2] = m_idx / 5 + 1;
                end
                for (int i = 0; i < 3; i++) begin
                    m_v[i] = oe[i] && (m_c[i] != 0);
                    if (m_st == 1)      m_y[i] = m_v[i];
                    else if (m_st == 2) m_y[i] = 1'b0;
                    else if (m_c[i] == 1) m_y[i] = m_v[i] && src;
                    else m_y[i] = m_v[i] && ((m_div >> (m_c[i] - 2)) & 1);
                end
            end
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        n_vec++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s at %0t: actual=%0d expected=%0d", tag, $time, act, exp);
        end
    endtask

    task automatic compare();
        string tag;
        for (int i = 0; i < 3; i++) begin
            if (en != 2'b11 && m_v == 0)   tag = "R2";
            else if (m_st == 1 || m_st == 2) tag = "R3";
            else if (i == 0)               tag = "R4";
            else if (m_err)                tag = "R7";
            else if (!oe[i])               tag = "R8";
            else if (sel_chg)              tag = "R9";
            else if (i == 1)               tag = "R5";
            else                           tag = "R6";
            chk($sformatf("%s lane%0d level", tag, i), int'(y[i]), int'(m_y[i]));
            chk($sformatf("%s lane%0d drive", tag, i), int'(drv[i]), int'(m_v[i]));
        end
        chk(m_err ? "R7 error flag" : "R2 error flag", int'(err), int'(m_err));
    endtask

    task automatic cycle();
        @(negedge clk);
        compare();
        sel_chg = 0;
        ph++;
        if (ph >= half) begin ph = 0; src = ~src; end
    endtask

    task automatic run(input int n);
        for (int k = 0; k < n; k++) cycle();
    endtask

    task automatic setsel(input int t);
        s0 = enc(t % 3);
        s1 = enc((t / 3) % 3);
        s2 = enc(t / 9);
        sel_chg = 1;
    endtask

    initial begin
        // R1: reset state
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            chk("R1 clk_out", int'(y), 0);
            chk("R1 out_drive", int'(drv), 0);
            chk("R1 mode_err", int'(err), 0);
        end
        rst_n = 1'b1;
        run(100);
        for (int t = 0; t < 27; t++) begin
            setsel(t);
            run(70);
        end
        s1 = 2'b10; sel_chg = 1;          // R7 invalid code
        run(20);
        setsel(23);
        run(40);
        oe = 3'b011; run(37);             // R8 mute lane 2, divider continues
        oe = 3'b111; run(50);
        oe = 3'b110; run(21);
        oe = 3'b111; run(10);
        en = 2'b01; s0 = 2'b10; run(15);  // R2 mid enable, selects ignored
        en = 2'b00; run(5);
        setsel(12);
        half = 3;
        en = 2'b11; oe = 3'b101; run(30); // R3 settle with one lane muted
        oe = 3'b111; run(150);
        for (int k = 0; k < 6; k++) begin // disables across source phases
            run(k);
            en = 2'b00; run(3);
            en = 2'b11; run(90);
        end
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL R4 watchdog: actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end
endmodule